// File: doc/BRIEF.md
# Selectable-Rate SPI Master Byte Engine

This block is a full-duplex SPI master that exchanges one byte per request. A small rate code chooses how fast SCK toggles. Some codes select a fixed divide of the system clock. The others select a half-period counted in pulses of a slow reference tick, and that count doubles from one code to the next. The caller presents a byte together with a one-cycle request. The engine shifts the byte out on MOSI and collects eight MISO samples. When the byte is finished it returns the received byte with a one-cycle done pulse.

Each bit follows the same sequence. MOSI is set, MISO is sampled, and SCK is raised in the same clock. SCK then stays high for one half-period and low for one half-period. SCK rests low between bytes. A connect input controls the pins. While it is low, the pin output-enable is off, SCK and MOSI are driven low, and any transfer in progress is dropped. The engine also reports the tick delay that a reset-pulse sequencer outside the block should use for the selected code.

Top module: `spi_rate_master`

## Requirements
- R1: Bits leave MSB first. MOSI carries bit 7 of the request byte during the first SCK high phase and bit 0 during the eighth. The MISO level sampled at the first SCK rise becomes bit 7 of the received byte, and the level sampled at the eighth rise becomes bit 0.
- R2: Rate codes 1, 2, 3, 4 and 5 divide the system clock by 8, 16, 32, 64 and 128. Each SCK high phase and each SCK low phase lasts N/2 clocks, where N is the divide ratio. done_o is high exactly 8*N clocks after the clock in which SCK first rises.
- R3: Rate code 0 (automatic) and the unused codes 13, 14 and 15 behave exactly like code 3 (divide by 32).
- R4: Rate codes 6 to 12 select a half-period of D = 3 << (code-6) reference ticks, which gives 3, 6, 12, 24, 48, 96 or 192. The engine counts the ticks on an 8-bit free-running counter with wraparound-safe subtraction. Each SCK phase therefore lasts from 4*D-4 to 4*D+1 clocks when a tick arrives every 4 clocks.
- R5: One clock after a rate code is applied, rst_delay_o shows 1 for codes 0 to 5 and 13 to 15, and shows D for codes 6 to 12. It shows 1 after reset.
- R6: done_o is a single-clock pulse that comes after the eighth low phase. busy_o is high from the clock after a request is accepted until the clock in which done_o is high.
- R7: A request is ignored while busy_o is high or while connect_i is low. The ignored request changes neither the byte being shifted nor the rate in use, and it does not start another transfer afterwards.
- R8: One clock after connect_i goes low, pin_oe_o, sck_o, mosi_o and busy_o are all low. A transfer that was in progress ends without a done pulse.
- R9: While reset is asserted, sck_o, mosi_o, pin_oe_o, done_o and busy_o are 0 and rx_byte_o is 0x00. SCK is low whenever the engine is idle.
- R10: The rate is captured when a request is accepted. Changing rate_sel_i during a transfer does not change that transfer's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Reference tick pulse, one clock wide |
| connect_i | input | 1 | High to drive the pins; low makes them float (drive low) |
| rate_sel_i | input | 4 | Rate code |
| req_i | input | 1 | Start a byte transfer |
| tx_byte_i | input | 8 | Byte to send, taken with the request |
| rx_byte_o | output | 8 | Received byte, valid with done_o |
| done_o | output | 1 | One-clock pulse at the end of a transfer |
| busy_o | output | 1 | Transfer in progress |
| rst_delay_o | output | 8 | Tick delay for reset pulsing under the current code |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| pin_oe_o | output | 1 | Output enable for SCK, MOSI and the reset pin |
| miso_i | input | 1 | Serial data in |

## Verification
A faulty phase counter or a wrong rate decode makes the first SCK high phase the wrong length. That shows at the port within the first half-period, and the end-of-byte cycle count confirms it. A wrong bit index or shift register produces a corrupted byte on MOSI or rx_byte_o by the time done_o rises. It can also produce a missing done pulse, a doubled one, or one at the wrong time. A state machine that does not honour connect_i or its busy state shows up within one clock as a live output enable or a transfer started by an ignored request.

// File: rtl/spi_rate_pkg.sv
package spi_rate_pkg;
  localparam int CODE_W        = 4;
  localparam int TICK_W        = 8;
  localparam int HALF_W        = 8;
  localparam int FAST_FIRST    = 1;
  localparam int FAST_LAST     = 5;
  localparam int SLOW_FIRST    = 6;
  localparam int SLOW_LAST     = 12;
  localparam int FAST_MIN_HALF = 4;   // divide by 8 -> 4 clocks per phase
  localparam int DEFAULT_HALF  = 16;  // divide by 32
  localparam int SLOW_MIN_DLY  = 3;

  typedef struct packed {
    logic              slow;
    logic [HALF_W-1:0] half_clks;
    logic [TICK_W-1:0] dly_ticks;
  } rate_cfg_t;

  typedef enum logic [1:0] {ST_IDLE, ST_HIGH, ST_LOW} xfer_state_t;
endpackage

// File: rtl/spi_rate_decode.sv
module spi_rate_decode
  import spi_rate_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output rate_cfg_t         cfg_o
);
  localparam logic [CODE_W-1:0] FAST_LO = CODE_W'(FAST_FIRST);
  localparam logic [CODE_W-1:0] FAST_HI = CODE_W'(FAST_LAST);
  localparam logic [CODE_W-1:0] SLOW_LO = CODE_W'(SLOW_FIRST);
  localparam logic [CODE_W-1:0] SLOW_HI = CODE_W'(SLOW_LAST);

  always_comb begin
    cfg_o.slow      = 1'b0;
    cfg_o.half_clks = HALF_W'(DEFAULT_HALF);
    cfg_o.dly_ticks = TICK_W'(1);
    if (code_i >= FAST_LO && code_i <= FAST_HI) begin
      cfg_o.half_clks = HALF_W'(FAST_MIN_HALF) << (code_i - FAST_LO);
    end else if (code_i >= SLOW_LO && code_i <= SLOW_HI) begin
      cfg_o.slow      = 1'b1;
      cfg_o.dly_ticks = TICK_W'(SLOW_MIN_DLY) << (code_i - SLOW_LO);
    end
  end
endmodule

// File: rtl/spi_tick_count.sv
module spi_tick_count #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk) begin
    if (rst)         cnt_o <= '0;
    else if (tick_i) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/spi_phase_timer.sv
module spi_phase_timer #(
  parameter int HALF_W = 8,
  parameter int TICK_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active_i,
  input  logic              start_i,
  input  logic              slow_i,
  input  logic [HALF_W-1:0] half_clks_i,
  input  logic [TICK_W-1:0] dly_ticks_i,
  input  logic [TICK_W-1:0] tick_cnt_i,
  output logic              expire_o
);
  logic [HALF_W-1:0] clk_cnt;
  logic [TICK_W-1:0] tick_base;
  logic [TICK_W-1:0] elapsed;

  assign elapsed  = tick_cnt_i - tick_base;   // wraps safely at 2**TICK_W
  assign expire_o = active_i &&
                    (slow_i ? (elapsed >= dly_ticks_i)
                            : (clk_cnt == half_clks_i - 1'b1));

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_cnt   <= '0;
      tick_base <= '0;
    end else if (start_i) begin
      clk_cnt   <= '0;
      tick_base <= tick_cnt_i;
    end else if (active_i) begin
      clk_cnt   <= clk_cnt + 1'b1;
    end
  end

  // R2
  phase_len_chk: assert property (@(posedge clk) disable iff (rst)
    (active_i && !slow_i && !start_i) |-> (clk_cnt < half_clks_i));
endmodule

// File: rtl/spi_rate_master.sv
module spi_rate_master
  import spi_rate_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              connect_i,
  input  logic [CODE_W-1:0] rate_sel_i,
  input  logic              req_i,
  input  logic [DATA_W-1:0] tx_byte_i,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic              done_o,
  output logic              busy_o,
  output logic [TICK_W-1:0] rst_delay_o,
  output logic              sck_o,
  output logic              mosi_o,
  output logic              pin_oe_o,
  input  logic              miso_i
);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

  xfer_state_t       state;
  rate_cfg_t         cfg_now, cfg_q;
  logic [DATA_W-1:0] shreg;
  logic [IDX_W-1:0]  bit_idx;
  logic [TICK_W-1:0] tick_cnt;
  logic              expire, accept, phase_start;

  spi_rate_decode u_dec (.code_i(rate_sel_i), .cfg_o(cfg_now));

  spi_tick_count #(.W(TICK_W)) u_tick (
    .clk(clk), .rst(rst), .tick_i(tick_i), .cnt_o(tick_cnt));

  spi_phase_timer #(.HALF_W(HALF_W), .TICK_W(TICK_W)) u_tmr (
    .clk(clk), .rst(rst),
    .active_i(state != ST_IDLE && connect_i),
    .start_i(phase_start),
    .slow_i(cfg_q.slow),
    .half_clks_i(cfg_q.half_clks),
    .dly_ticks_i(cfg_q.dly_ticks),
    .tick_cnt_i(tick_cnt),
    .expire_o(expire));

  assign accept      = (state == ST_IDLE) && req_i && connect_i;
  assign phase_start = accept || expire;
  assign busy_o      = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      cfg_q       <= '0;
      shreg       <= '0;
      bit_idx     <= '0;
      rx_byte_o   <= '0;
      done_o      <= 1'b0;
      sck_o       <= 1'b0;
      mosi_o      <= 1'b0;
      pin_oe_o    <= 1'b0;
      rst_delay_o <= TICK_W'(1);
    end else begin
      rst_delay_o <= cfg_now.slow ? cfg_now.dly_ticks : TICK_W'(1);
      done_o      <= 1'b0;
      if (!connect_i) begin
        state    <= ST_IDLE;
        sck_o    <= 1'b0;
        mosi_o   <= 1'b0;
        pin_oe_o <= 1'b0;
      end else begin
        pin_oe_o <= 1'b1;
        unique case (state)
          ST_IDLE: if (accept) begin
            cfg_q     <= cfg_now;
            mosi_o    <= tx_byte_i[DATA_W-1];
            shreg     <= {tx_byte_i[DATA_W-2:0], 1'b0};
            rx_byte_o <= {rx_byte_o[DATA_W-2:0], miso_i};
            sck_o     <= 1'b1;
            bit_idx   <= '0;
            state     <= ST_HIGH;
          end
          ST_HIGH: if (expire) begin
            sck_o <= 1'b0;
            state <= ST_LOW;
          end
          ST_LOW: if (expire) begin
            if (bit_idx == LAST_IDX) begin
              done_o <= 1'b1;
              state  <= ST_IDLE;
            end else begin
              bit_idx   <= bit_idx + 1'b1;
              mosi_o    <= shreg[DATA_W-1];
              shreg     <= {shreg[DATA_W-2:0], 1'b0};
              rx_byte_o <= {rx_byte_o[DATA_W-2:0], miso_i};
              sck_o     <= 1'b1;
              state     <= ST_HIGH;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R8
  disc_pins_chk: assert property (@(posedge clk) disable iff (rst)
    !connect_i |=> (!pin_oe_o && !sck_o && !mosi_o && !busy_o));
  // R9
  idle_sck_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !sck_o);
  // R5
  fast_rst_dly_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_now.slow |=> (rst_delay_o == TICK_W'(1)));
  // R7
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !expire) |=> busy_o || !connect_i);
endmodule

// File: tb/sim_spi_rate_master.sv
module sim_spi_rate_master;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_i = 1'b0;
  logic       connect_i = 1'b1;
  logic [3:0] rate_sel_i = 4'd0;
  logic       req_i = 1'b0;
  logic [7:0] tx_byte_i = 8'h00;
  logic [7:0] rx_byte_o;
  logic       done_o, busy_o, sck_o, mosi_o, pin_oe_o;
  logic [7:0] rst_delay_o;
  logic       miso_i = 1'b0;

  int total = 0, bad = 0, cyc = 0;
  logic [7:0] sb = 8'h00, mosi_cap = 8'h00;
  int k = 0;

  spi_rate_master u0 (.*);

  always #10 clk = ~clk;   // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    int tc = 0;
    forever begin
      @(negedge clk);
      tc++;
      tick_i = (tc % 4 == 0);
    end
  end

  // slave model: next bit after each SCK fall, capture MOSI while SCK high
  always @(negedge sck_o) begin
    mosi_cap = {mosi_cap[6:0], mosi_o};
    if (k < 7) begin
      k++;
      miso_i = sb[7-k];
    end
  end

  function automatic bit is_slow(input logic [3:0] c);
    return (c >= 6 && c <= 12);
  endfunction
  function automatic int exp_div(input logic [3:0] c);
    if (c >= 1 && c <= 5) return 8 << (c - 1);
    return 32;
  endfunction
  function automatic int exp_dly(input logic [3:0] c);
    if (is_slow(c)) return 3 << (c - 6);
    return 1;
  endfunction

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic xfer(input logic [3:0] code, input logic [7:0] tx,
                      input logic [7:0] s, input int poke);
    int c0, hi, guard;
    bit seen_low;
    @(negedge clk);
    rate_sel_i = code; tx_byte_i = tx; sb = s; k = 0; miso_i = s[7];
    mosi_cap = 8'h00; req_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
    c0 = cyc; hi = 0; seen_low = 0; guard = 0;
    chk(busy_o && sck_o, "R6", busy_o, 1);
    while (!done_o && guard < 40000) begin
      if (sck_o && !seen_low) hi++; else seen_low = 1;
      if (guard == poke) begin
        req_i = 1'b1; tx_byte_i = ~tx; rate_sel_i = 4'd5;
      end else begin
        req_i = 1'b0;
      end
      @(negedge clk);
      guard++;
    end
    req_i = 1'b0;
    chk(done_o, "R6", done_o, 1);
    chk(busy_o == 1'b0, "R6", busy_o, 0);
    chk(rx_byte_o == s, "R1", rx_byte_o, s);
    chk(mosi_cap == tx, "R1", mosi_cap, tx);
    if (is_slow(code)) begin
      chk(hi >= 4*exp_dly(code)-4 && hi <= 4*exp_dly(code)+1, "R4", hi, 4*exp_dly(code));
    end else begin
      chk(hi == exp_div(code)/2, "R2", hi, exp_div(code)/2);
      chk(cyc - c0 == 8*exp_div(code), "R2/R3/R10", cyc - c0, 8*exp_div(code));
    end
    @(negedge clk);
    chk(!done_o && !sck_o, "R6", done_o, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL R6 watchdog actual=%0d expected=%0d", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(!sck_o && !mosi_o && !pin_oe_o && !done_o && !busy_o, "R9", sck_o, 0);
    chk(rx_byte_o == 8'h00, "R9", rx_byte_o, 0);
    chk(rst_delay_o == 8'd1, "R5", rst_delay_o, 1);
    rst = 1'b0;
    @(negedge clk);
    chk(pin_oe_o, "R8", pin_oe_o, 1);

    // R5 every code
    for (int c = 0; c < 16; c++) begin
      rate_sel_i = 4'(c);
      @(negedge clk);
      chk(rst_delay_o == 8'(exp_dly(4'(c))), "R5", rst_delay_o, exp_dly(4'(c)));
    end

    // directed: each fast code, auto, unused codes
    for (int c = 0; c < 6; c++) xfer(4'(c), 8'hA5, 8'h3C, -1);
    xfer(4'd13, 8'h81, 8'h7E, -1);   // R3
    xfer(4'd15, 8'h00, 8'hFF, -1);   // R3
    // random fast traffic
    for (int i = 0; i < 16; i++) begin
      int r;
      logic [3:0] code;
      r = $urandom_range(0, 8);
      code = (r <= 5) ? 4'(r) : 4'(r + 7);
      xfer(code, 8'($urandom), 8'($urandom), -1);
    end
    // slow rates (R4), including the longest delay
    xfer(4'd6, 8'hC3, 8'h5A, -1);
    xfer(4'd7, 8'h1E, 8'hE1, -1);
    xfer(4'd12, 8'h96, 8'h69, -1);

    // R7 / R10: request and rate change while busy
    xfer(4'd2, 8'h5B, 8'hB5, 20);
    repeat (20) @(negedge clk);
    chk(!busy_o, "R7", busy_o, 0);

    // R8: disconnect mid-transfer
    @(negedge clk);
    rate_sel_i = 4'd5; tx_byte_i = 8'hFF; req_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
    repeat (100) @(negedge clk);
    connect_i = 1'b0;
    @(negedge clk);
    chk(!pin_oe_o && !sck_o && !mosi_o && !busy_o, "R8", pin_oe_o, 0);
    begin
      int dn = 0;
      for (int i = 0; i < 1200; i++) begin
        if (done_o) dn++;
        @(negedge clk);
      end
      chk(dn == 0, "R8", dn, 0);
    end
    // R7: request while disconnected
    req_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
    @(negedge clk);
    chk(!busy_o && !sck_o, "R7", busy_o, 0);
    connect_i = 1'b1;
    @(negedge clk);
    chk(pin_oe_o && !busy_o, "R8", pin_oe_o, 1);
    xfer(4'd1, 8'h6D, 8'hD6, -1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule